// File: doc/BRIEF.md
# Descriptor Queue Manager

This block keeps descriptor pointers in a set of numbered first-in first-out queues. All queues share one linked-list store of parameterised depth. Software and DMA engines reach the block through a simple register bus. Each queue has a group of four registers, 16 bytes apart. The last register of a group is a combined port: a write to it appends a 32-bit word to that queue, and a read from it removes the oldest word and returns it. A word is a 32-byte-aligned descriptor address. Its five low bits carry a size hint equal to (descriptor bytes − 24)/4. The block stores the word unchanged and returns it unchanged, so the reader masks those bits off to recover the address.

A small bank of 32-bit status words, starting at byte 0x90, holds one flag per queue. The flag is set while that queue holds at least one entry. A polling agent or an interrupt layer reads these words to find which completion queues have work. A push that finds the shared store full is discarded and sets a sticky overflow output.

Top module: `desc_queue_mgr`

## Requirements
- R1: A write to byte address 0x2000 + 16·q + 0xC (q < NUM_QUEUES) enqueues the full 32-bit write data on queue q. A later read of that address returns the same 32 bits, including the 5-bit size hint in bits 4:0.
- R2: Words leave a queue in the order they were pushed.
- R3: A read of the port of an empty queue returns zero and changes no queue.
- R4: Status word i is read at byte address 0x90 + 4·i, for i from 0 to ceil(NUM_QUEUES/32)−1. Bit q mod 32 of word q/32 is 1 exactly when queue q is non-empty. Bits for queue numbers at or above NUM_QUEUES read 0.
- R5: A read issued in the cycle right after a push or pop already shows the new value of that queue's status bit.
- R6: Queues are independent: interleaved pushes to different queues keep each queue's own order.
- R7: At most LIST_DEPTH words are held across all queues. A push while the block holds LIST_DEPTH words is discarded and leaves stored contents unchanged. It also sets `overflow`, which stays 1 until reset.
- R8: Entries freed by pops are reused, so more than LIST_DEPTH pushes in total succeed when pops are interleaved.
- R9: Each read returns its data with `bus_rvalid` = 1 in the cycle after `bus_rd`. `bus_rvalid` is 1 for exactly one cycle per read. Reads of addresses that are neither a queue port nor a status word return 0.
- R10: After reset all queues are empty, every status word reads 0, and `overflow` is 0.
- R11: Writes to offsets 0x0, 0x4 and 0x8 of a queue group, to queue groups numbered NUM_QUEUES or higher, or to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| overflow | output | 1 | Sticky flag: a push was dropped because the store was full |

## Verification
The checks assume a bus master that never asserts read and write in the same cycle. They also assume the top-level decode never pops an empty queue or pushes into a full store. The bench drives every access as a one-cycle strobe set up on the falling edge, so the two strobes are never high together. Probing empty queues, full-store pushes and invalid addresses then exercises the internal guards rather than bypassing them.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned SIZE_W    = 5;
    localparam int unsigned GRP_BYTES = 16;
    localparam int unsigned PORT_OFS  = 12;
    localparam int unsigned QREG_BASE = 32'h2000;
    localparam int unsigned STAT_BASE = 32'h90;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_QPORT = 2'd1,
        ACC_STAT  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/dqm_link_store.sv
module dqm_link_store #(
    parameter int unsigned LIST_DEPTH = 64,
    localparam int unsigned PTR_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_en,
    input  logic [dqm_pkg::WORD_W-1:0] push_data,
    input  logic                      link_en,
    input  logic [PTR_W-1:0]          link_tail,
    input  logic                      pop_en,
    input  logic [PTR_W-1:0]          pop_head,
    output logic [PTR_W-1:0]          alloc_slot,
    output logic                      full,
    output logic [dqm_pkg::WORD_W-1:0] head_data,
    output logic [PTR_W-1:0]          head_next
);
    localparam int unsigned CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] bump;
        logic [CNT_W-1:0] used;
        logic [PTR_W-1:0] free_head;
    } store_regs_t;

    store_regs_t st_d, st_q;
    logic [dqm_pkg::WORD_W-1:0] data_mem [LIST_DEPTH];
    logic [PTR_W-1:0]           next_mem [LIST_DEPTH];
    logic                       from_free;

    always_comb begin
        st_d       = st_q;
        from_free  = (st_q.bump > st_q.used);
        alloc_slot = from_free ? st_q.free_head : PTR_W'(st_q.bump);
        full       = (st_q.used == CNT_W'(LIST_DEPTH));
        head_data  = data_mem[pop_head];
        head_next  = next_mem[pop_head];
        if (push_en) begin
            st_d.used = st_q.used + 1'b1;
            if (from_free) begin
                st_d.free_head = next_mem[st_q.free_head];
            end else begin
                st_d.bump = st_q.bump + 1'b1;
            end
        end else if (pop_en) begin
            st_d.used      = st_q.used - 1'b1;
            st_d.free_head = pop_head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) begin
            data_mem[alloc_slot] <= push_data;
            if (link_en) begin
                next_mem[link_tail] <= alloc_slot;
            end
        end else if (pop_en) begin
            next_mem[pop_head] <= st_q.free_head;
        end
    end

    // R7
    store_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= CNT_W'(LIST_DEPTH));
    // R7
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !full);
    // R3
    pop_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (st_q.used != '0));
endmodule

// File: rtl/dqm_queue_table.sv
module dqm_queue_table #(
    parameter int unsigned NUM_QUEUES = 160,
    parameter int unsigned PTR_W      = 6,
    localparam int unsigned QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [QW-1:0]         sel_q,
    input  logic                  do_push,
    input  logic [PTR_W-1:0]      push_slot,
    input  logic                  do_pop,
    input  logic [PTR_W-1:0]      pop_next,
    output logic [PTR_W-1:0]      sel_head,
    output logic [PTR_W-1:0]      sel_tail,
    output logic                  sel_busy,
    output logic [NUM_QUEUES-1:0] busy_vec
);
    typedef struct packed {
        logic             busy;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } qent_t;

    qent_t tbl_d [NUM_QUEUES];
    qent_t tbl_q [NUM_QUEUES];

    always_comb begin
        tbl_d    = tbl_q;
        sel_head = tbl_q[sel_q].head;
        sel_tail = tbl_q[sel_q].tail;
        sel_busy = tbl_q[sel_q].busy;
        if (do_push) begin
            tbl_d[sel_q].tail = push_slot;
            tbl_d[sel_q].busy = 1'b1;
            if (!tbl_q[sel_q].busy) begin
                tbl_d[sel_q].head = push_slot;
            end
        end else if (do_pop) begin
            if (tbl_q[sel_q].head == tbl_q[sel_q].tail) begin
                tbl_d[sel_q].busy = 1'b0;
            end else begin
                tbl_d[sel_q].head = pop_next;
            end
        end
    end

    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_busy
        assign busy_vec[g] = tbl_q[g].busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_QUEUES; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R3
    pop_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |-> sel_busy);
    // R5
    push_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> busy_vec[$past(sel_q)]);
    // R5
    pop_last_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && sel_head == sel_tail) |=> !busy_vec[$past(sel_q)]);
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr #(
    parameter int unsigned NUM_QUEUES = 160,
    parameter int unsigned LIST_DEPTH = 64,
    parameter int unsigned ADDR_W     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              overflow
);
    import dqm_pkg::*;

    localparam int unsigned QW     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
    localparam int unsigned PTR_W  = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1;
    localparam int unsigned NSTAT  = (NUM_QUEUES + 31) / 32;
    localparam int unsigned SIDX_W = (NSTAT > 1) ? $clog2(NSTAT) : 1;
    localparam int unsigned GRP_W  = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] QBASE_A = ADDR_W'(QREG_BASE);
    localparam logic [ADDR_W-1:0] SBASE_A = ADDR_W'(STAT_BASE);
    localparam logic [ADDR_W-1:0] SEND_A  = ADDR_W'(STAT_BASE + 4 * NSTAT);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
        logic              ovf;
    } top_regs_t;

    top_regs_t r_d, r_q;

    acc_kind_e           acc_kind;
    logic [ADDR_W-1:0]   q_off;
    logic [ADDR_W-1:0]   s_off;
    logic [GRP_W-1:0]    q_grp;
    logic [QW-1:0]       sel_q;
    logic [SIDX_W-1:0]   s_idx;
    logic [NSTAT*32-1:0] stat_flat;
    logic [NUM_QUEUES-1:0] busy_vec;
    logic                do_push, do_pop, sel_busy, full;
    logic [PTR_W-1:0]    sel_head, sel_tail, alloc_slot, head_next;
    logic [WORD_W-1:0]   head_data;

    always_comb begin
        q_off    = bus_addr - QBASE_A;
        s_off    = bus_addr - SBASE_A;
        q_grp    = GRP_W'(q_off >> 4);
        sel_q    = QW'(q_grp);
        s_idx    = SIDX_W'(s_off >> 2);
        acc_kind = ACC_NONE;
        if ((bus_addr >= QBASE_A) && (bus_addr[3:0] == 4'(PORT_OFS))
            && (32'(q_grp) < NUM_QUEUES)) begin
            acc_kind = ACC_QPORT;
        end else if ((bus_addr >= SBASE_A) && (bus_addr < SEND_A)
                     && (bus_addr[1:0] == 2'b00)) begin
            acc_kind = ACC_STAT;
        end
        stat_flat                   = '0;
        stat_flat[NUM_QUEUES-1:0]   = busy_vec;
        do_push = bus_wr && (acc_kind == ACC_QPORT) && !full;
        do_pop  = bus_rd && (acc_kind == ACC_QPORT) && sel_busy;
    end

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = bus_rd;
        if (bus_rd) begin
            case (acc_kind)
                ACC_QPORT: r_d.rdata = sel_busy ? head_data : '0;
                ACC_STAT:  r_d.rdata = stat_flat[32*s_idx +: 32];
                default:   r_d.rdata = '0;
            endcase
        end
        if (bus_wr && (acc_kind == ACC_QPORT) && full) begin
            r_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata  = r_q.rdata;
    assign bus_rvalid = r_q.rvalid;
    assign overflow   = r_q.ovf;

    dqm_queue_table #(
        .NUM_QUEUES (NUM_QUEUES),
        .PTR_W      (PTR_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_q     (sel_q),
        .do_push   (do_push),
        .push_slot (alloc_slot),
        .do_pop    (do_pop),
        .pop_next  (head_next),
        .sel_head  (sel_head),
        .sel_tail  (sel_tail),
        .sel_busy  (sel_busy),
        .busy_vec  (busy_vec)
    );

    dqm_link_store #(
        .LIST_DEPTH (LIST_DEPTH)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (do_push),
        .push_data  (bus_wdata),
        .link_en    (sel_busy),
        .link_tail  (sel_tail),
        .pop_en     (do_pop),
        .pop_head   (sel_head),
        .alloc_slot (alloc_slot),
        .full       (full),
        .head_data  (head_data),
        .head_next  (head_next)
    );

    // R9
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
    // R9
    read_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    // R9
    no_spurious_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/desc_queue_mgr_tb.sv
module desc_queue_mgr_tb_top;
    localparam int NQ    = 160;
    localparam int DEPTH = 64;
    localparam int AW    = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    int reads_issued = 0;
    int replies_seen = 0;
    int held = 0;
    bit finished = 1'b0;

    logic [31:0] mdl [NQ][$];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    desc_queue_mgr #(.NUM_QUEUES(NQ), .LIST_DEPTH(DEPTH), .ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .overflow   (overflow)
    );

    function automatic logic [AW-1:0] port_addr(int q);
        return AW'(32'h2000 + q * 16 + 12);
    endfunction

    function automatic logic [31:0] stat_word(int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++) begin
            if ((w * 32 + b) < NQ && mdl[w * 32 + b].size() != 0) v[b] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic raw_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push(int q, logic [31:0] d);
        if (held < DEPTH) begin
            mdl[q].push_back(d);
            held++;
        end
        raw_write(port_addr(q), d);
    endtask

    task automatic raw_read(logic [AW-1:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        reads_issued++;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        check("R9 reply latency", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic pop(int q, string req);
        logic [31:0] e = '0;
        if (mdl[q].size() != 0) begin
            e = mdl[q].pop_front();
            held--;
        end
        raw_read(port_addr(q), e, req);
    endtask

    task automatic read_stat(int w, string req);
        raw_read(AW'(32'h90 + 4 * w), stat_word(w), req);
    endtask

    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            replies_seen++;
            if (exp_q.size() == 0) begin
                check("R9 unexpected reply", bus_rdata, 32'hx);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 overflow", 32'(overflow), 32'd0);
        for (int w = 0; w < 5; w++) read_stat(w, "R10 status");
        pop(7, "R10 empty queue");

        // R1: single word round trip with size hint 0x05
        push(0, 32'h0000_1045);
        pop(0, "R1 round trip");
        // R3: now empty
        pop(0, "R3 empty reads zero");
        read_stat(0, "R3 status unchanged");

        // R5: status visible the cycle after push and pop
        push(5, 32'h0000_2040);
        read_stat(0, "R5 after push");
        pop(5, "R5 data");
        read_stat(0, "R5 after pop");

        // R2 / R4: order and status bit position for queue 93
        for (int i = 0; i < 4; i++) push(93, 32'h0001_0000 + 32'(i * 32 + i));
        read_stat(2, "R4 queue 93 bit");
        for (int i = 0; i < 4; i++) pop(93, "R2 fifo order");

        // R6: interleaved queues
        push(1, 32'hA000_0001); push(159, 32'hB000_0002);
        push(1, 32'hA000_0023); push(159, 32'hB000_0044);
        push(64, 32'hC000_001F);
        read_stat(0, "R4 word0"); read_stat(2, "R4 word2"); read_stat(4, "R4 word4");
        pop(159, "R6 q159"); pop(1, "R6 q1"); pop(1, "R6 q1");
        pop(159, "R6 q159"); pop(64, "R6 q64");

        // R11: ignored writes
        raw_write(AW'(32'h2000 + 3 * 16 + 0), 32'hDEAD_0001);
        raw_write(AW'(32'h2000 + 3 * 16 + 4), 32'hDEAD_0002);
        raw_write(AW'(32'h2000 + 3 * 16 + 8), 32'hDEAD_0003);
        raw_write(port_addr(160), 32'hDEAD_0004);
        raw_write(AW'(32'h0010), 32'hDEAD_0005);
        pop(3, "R11 other offsets ignored");
        raw_read(port_addr(160), 32'h0, "R11 queue beyond range");
        raw_read(AW'(32'h0010), 32'h0, "R9 unmapped read");
        for (int w = 0; w < 5; w++) read_stat(w, "R11 status clear");

        // R7: fill the store, then overflow
        for (int i = 0; i < DEPTH; i++) push(10 + i % 3, 32'(i * 32 + i % 32));
        check("R7 not yet overflow", 32'(overflow), 32'd0);
        push(10, 32'hFFFF_FFE0);
        check("R7 overflow set", 32'(overflow), 32'd1);
        read_stat(0, "R7 status while full");
        for (int q = 10; q < 13; q++) begin
            while (mdl[q].size() != 0) pop(q, "R7 contents intact");
        end
        pop(10, "R7 dropped word absent");

        // R8: reuse of freed entries
        for (int i = 0; i < DEPTH; i++) push(20, 32'h5000_0000 + 32'(i * 32));
        check("R7 overflow sticky", 32'(overflow), 32'd1);
        for (int i = 0; i < DEPTH; i++) pop(20, "R8 reuse");
        pop(20, "R8 drained");
        read_stat(0, "R8 status clear");

        repeat (2) @(negedge clk);
        check("R9 one reply per read", 32'(replies_seen), 32'(reads_issued));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule